// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is the serial core of an SPI master. It sits between a byte-wide transmit queue and a byte-wide receive queue, each 64 entries deep. It clocks out a burst of whole bytes on MOSI and captures MISO at the same time. The surrounding register logic supplies the settings on plain input pins: enable, master select, clock polarity, clock phase, bit order and receive discard. It also supplies two byte counts and a one-cycle start request. A separate divider supplies `sck_tick_i`, and each tick marks one half-period of SCK.

The burst length sets how many bytes are clocked on the bus. The transmit length sets how many of those bytes are taken from the transmit queue. Once the transmit length is used up, every remaining byte is sent as 0x00 and the queue is not read. In discard mode, captured bytes are dropped instead of being queued. This suits writes to a device that returns nothing useful. When the last byte ends, the busy flag drops and a sticky completion flag rises in the same cycle. The completion flag is cleared by a one-cycle clear pulse. It reaches the interrupt line only while the interrupt enable input is high.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, busy, completion flag and interrupt are low, both queue levels read zero, and SCK rests at the level of `cpol_i`.
- R2: With phase 0 and MSB-first order, each burst byte is driven most significant bit first. MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. Each byte takes exactly 16 SCK edges, and the captured bytes enter the receive queue in bus order.
- R3: All four combinations of polarity and phase work. Polarity sets the idle SCK level. With phase 1, data changes on the leading edge and is sampled on the trailing edge. SCK changes only on cycles where `sck_tick_i` is high.
- R4: With `lsb_first_i` high, bit 0 of each byte goes first on MOSI, and the first received bit lands in bit 0.
- R5: Bytes with index below the transmit length are popped from the transmit queue in order. All later bytes of the burst are sent as 0x00, and the queue level stays unchanged while they go out.
- R6: While `rx_discard_i` is high, bytes received during a burst are not written to the receive queue, so its level does not grow.
- R7: `busy_o` rises the cycle after a start request accepted while idle. It falls in the same cycle the last byte finishes, and `tc_o` rises in that same cycle.
- R8: A start request with a burst length of zero completes one cycle after busy rises, and SCK never toggles.
- R9: `tc_o` is sticky until a `tc_clear_i` pulse. `irq_o` equals `tc_o` AND `irq_en_i`.
- R10: No byte starts unless both `en_i` and `master_i` are high. A pending request waits, with busy high and SCK idle, and then proceeds once both are set.
- R11: Each queue holds 64 bytes, and pushes into a full queue are ignored. The flush inputs empty a queue. `fifo_level_o` reports the receive level in bits [6:0] and the transmit level in bits [22:16], with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| master_i | input | 1 | Master-mode select |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Clock phase (1: sample on trailing edge) |
| lsb_first_i | input | 1 | Bit order (1: bit 0 first) |
| rx_discard_i | input | 1 | Drop received bytes |
| start_i | input | 1 | One-cycle burst start request |
| burst_len_i | input | 24 | Bytes clocked in the burst |
| tx_len_i | input | 24 | Bytes taken from the transmit queue |
| tx_flush_i | input | 1 | Empty the transmit queue |
| rx_flush_i | input | 1 | Empty the receive queue |
| tx_push_i | input | 1 | Write a byte to the transmit queue |
| tx_data_i | input | 8 | Byte to queue for transmission |
| rx_pop_i | input | 1 | Remove the head of the receive queue |
| rx_data_o | output | 8 | Head of the receive queue |
| fifo_level_o | output | 32 | Queue levels: rx [6:0], tx [22:16] |
| tc_clear_i | input | 1 | Clear the completion flag |
| irq_en_i | input | 1 | Completion interrupt enable |
| tc_o | output | 1 | Sticky burst-complete flag |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Burst requested and not finished |
| sck_tick_i | input | 1 | Half-period SCK tick from the divider |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench plays an SPI slave that counts SCK edges and derives its own sampling and driving points from the chosen mode. A wrong phase, polarity or bit order therefore shows up as corrupted bytes on one side or the other. Directed bursts cover each mode alone: a transmit length shorter than the burst, so that 0x00 padding shows apart from queued data; a zero-length start; discard mode; a full 64-byte burst; and a start that is held back by the enable gate. Random bursts then mix modes, lengths, tick spacing and extra queued bytes. The extra bytes expose a transmit queue that is read too often.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic {ENG_IDLE = 1'b0, ENG_RUN = 1'b1} eng_state_t;
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         initial $error("spi_burst_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> $stable(level));
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
   import spi_burst_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  cpol,
   input  logic  cpha,
   input  logic  lsb_first,
   input  logic  load,
   input  byte_t load_byte,
   input  logic  miso,
   output logic  sck,
   output logic  mosi,
   output logic  active,
   output logic  done,
   output byte_t rx_byte
);
   localparam int EDGES = 2 * BYTE_W;
   localparam int EW    = $clog2(EDGES);

   logic          sck_q;
   logic [EW-1:0] ecnt;
   byte_t         txsh, rxsh, rx_nx;
   logic          smp_edge;

   // Even edge counts are leading edges; phase picks which of them samples.
   assign smp_edge = cpha ? ecnt[0] : ~ecnt[0];
   assign rx_nx    = lsb_first ? {miso, rxsh[BYTE_W-1:1]} : {rxsh[BYTE_W-2:0], miso};
   assign mosi     = lsb_first ? txsh[0] : txsh[BYTE_W-1];
   assign sck      = active ? sck_q : cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         sck_q   <= 1'b0;
         ecnt    <= '0;
         txsh    <= '0;
         rxsh    <= '0;
         rx_byte <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            active <= 1'b1;
            sck_q  <= cpol;
            ecnt   <= '0;
            txsh   <= load_byte;
            rxsh   <= '0;
         end else if (active && tick) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + 1'b1;
            if (smp_edge) rxsh <= rx_nx;
            if (!smp_edge && ecnt != '0 && ecnt != EW'(EDGES - 1))
               txsh <= lsb_first ? (txsh >> 1) : (txsh << 1);
            if (ecnt == EW'(EDGES - 1)) begin
               active  <= 1'b0;
               done    <= 1'b1;
               rx_byte <= smp_edge ? rx_nx : rxsh;
            end
         end
      end
   end

   // R3
   sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick && !load) |=> $stable(sck_q));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
   import spi_burst_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int CNT_W      = 24,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             master_i,
   input  logic             cpol_i,
   input  logic             cpha_i,
   input  logic             lsb_first_i,
   input  logic             rx_discard_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] burst_len_i,
   input  logic [CNT_W-1:0] tx_len_i,
   input  logic             tx_flush_i,
   input  logic             rx_flush_i,
   input  logic             tx_push_i,
   input  logic [7:0]       tx_data_i,
   input  logic             rx_pop_i,
   output logic [7:0]       rx_data_o,
   output logic [31:0]      fifo_level_o,
   input  logic             tc_clear_i,
   input  logic             irq_en_i,
   output logic             tc_o,
   output logic             irq_o,
   output logic             busy_o,
   input  logic             sck_tick_i,
   output logic             sck_o,
   output logic             mosi_o,
   input  logic             miso_i
);
   generate
      if (LVL_W > 16) begin : g_bad_level
         initial $error("spi_burst_engine: level field exceeds 16 bits");
      end
   endgenerate

   eng_state_t       st_q;
   logic             xch_q, tc_q;
   logic [CNT_W-1:0] burst_left_q, tx_left_q;
   logic             run_ok, issue, zero_done, last_done, finish;
   logic             tx_pop, tx_empty, tx_full, rx_push, rx_full, rx_empty;
   logic [LVL_W-1:0] tx_lvl, rx_lvl;
   byte_t            tx_head, load_byte, sh_rx;
   logic             sh_active, sh_done;

   assign run_ok    = en_i && master_i;
   assign issue     = (st_q == ENG_IDLE) && xch_q && run_ok && (burst_left_q != '0)
                      && ((tx_left_q == '0) || !tx_empty);
   assign zero_done = (st_q == ENG_IDLE) && xch_q && run_ok && (burst_left_q == '0);
   assign last_done = (st_q == ENG_RUN) && sh_done && (burst_left_q == CNT_W'(1));
   assign finish    = zero_done || last_done;
   assign tx_pop    = issue && (tx_left_q != '0);
   assign load_byte = (tx_left_q != '0) ? tx_head : '0;
   assign rx_push   = sh_done && !rx_discard_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ENG_IDLE;
         xch_q        <= 1'b0;
         tc_q         <= 1'b0;
         burst_left_q <= '0;
         tx_left_q    <= '0;
      end else begin
         if (start_i && !xch_q) begin
            xch_q        <= 1'b1;
            burst_left_q <= burst_len_i;
            tx_left_q    <= tx_len_i;
         end else begin
            if (finish) xch_q <= 1'b0;
            if (issue) begin
               st_q <= ENG_RUN;
               if (tx_left_q != '0) tx_left_q <= tx_left_q - 1'b1;
            end
            if (st_q == ENG_RUN && sh_done) begin
               st_q         <= ENG_IDLE;
               burst_left_q <= burst_left_q - 1'b1;
            end
         end
         if (finish)          tc_q <= 1'b1;
         else if (tc_clear_i) tc_q <= 1'b0;
      end
   end

   spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush_i), .push(tx_push_i),
      .wdata(tx_data_i), .pop(tx_pop), .rdata(tx_head), .full(tx_full),
      .empty(tx_empty), .level(tx_lvl));

   spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush_i), .push(rx_push),
      .wdata(sh_rx), .pop(rx_pop_i), .rdata(rx_data_o), .full(rx_full),
      .empty(rx_empty), .level(rx_lvl));

   spi_burst_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .tick(sck_tick_i), .cpol(cpol_i), .cpha(cpha_i),
      .lsb_first(lsb_first_i), .load(issue), .load_byte(load_byte), .miso(miso_i),
      .sck(sck_o), .mosi(mosi_o), .active(sh_active), .done(sh_done), .rx_byte(sh_rx));

   always_comb begin
      fifo_level_o              = '0;
      fifo_level_o[LVL_W-1:0]   = rx_lvl;
      fifo_level_o[16 +: LVL_W] = tx_lvl;
   end

   assign busy_o = xch_q;
   assign tc_o   = tc_q;
   assign irq_o  = tc_q && irq_en_i;

   // R7
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xch_q) |-> tc_q);
   // R8
   idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xch_q |-> (sck_o == cpol_i));
   // R5
   pad_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xch_q && tx_left_q == '0 && !tx_push_i && !tx_flush_i) |=> (tx_lvl == $past(tx_lvl)));
   // R6
   discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_discard_i && !rx_pop_i && !rx_flush_i) |=> (rx_lvl == $past(rx_lvl)));
   // R10
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_ok && !sh_active) |=> !sh_active);
endmodule

// File: tb/spi_burst_engine_bench.sv
`timescale 1ns/1ps
module spi_burst_engine_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1, master = 1'b1, cpol = 1'b1, cpha = 1'b0, lsbf = 1'b0, disc = 1'b0;
   logic start = 1'b0;
   logic [23:0] blen = '0, tlen = '0;
   logic txfl = 1'b0, rxfl = 1'b0, txpush = 1'b0, rxpop = 1'b0;
   logic [7:0] txd = '0;
   logic [7:0] rxd;
   logic [31:0] lvl;
   logic tcclr = 1'b0, irqen = 1'b0;
   logic tc, irq, busy, tick, sck, mosi, miso;

   int nchk = 0, nfail = 0;
   int div = 0, tcnt = 0;
   int n_edges = 0;
   bit armed = 1'b0;
   int seedv = 0;
   logic [7:0] slv_rx [0:79];
   logic [7:0] txb [0:79];

   always #2 clk = ~clk;

   spi_burst_engine u_spi_burst_engine (
      .clk(clk), .rst_n(rst_n), .en_i(en), .master_i(master), .cpol_i(cpol),
      .cpha_i(cpha), .lsb_first_i(lsbf), .rx_discard_i(disc), .start_i(start),
      .burst_len_i(blen), .tx_len_i(tlen), .tx_flush_i(txfl), .rx_flush_i(rxfl),
      .tx_push_i(txpush), .tx_data_i(txd), .rx_pop_i(rxpop), .rx_data_o(rxd),
      .fifo_level_o(lvl), .tc_clear_i(tcclr), .irq_en_i(irqen), .tc_o(tc),
      .irq_o(irq), .busy_o(busy), .sck_tick_i(tick), .sck_o(sck), .mosi_o(mosi),
      .miso_i(miso));

   initial tick = 1'b0;
   always @(negedge clk) begin
      if (tcnt >= div) begin tick <= 1'b1; tcnt <= 0; end
      else begin tick <= 1'b0; tcnt <= tcnt + 1; end
   end

   function automatic logic [7:0] slave_byte(int k, int s);
      return 8'(k * 29 + s);
   endfunction

   function automatic int bit_pos(int n, logic ph, logic lf);
      int j, p;
      j = n % 16;
      p = ph ? ((j == 0) ? 0 : (j - 1) / 2) : j / 2;
      return lf ? p : 7 - p;
   endfunction

   logic [7:0] cur_slv;
   assign cur_slv = slave_byte(n_edges / 16, seedv);
   assign miso = cur_slv[bit_pos(n_edges, cpha, lsbf)];

   always @(sck) begin
      if (armed) begin
         int j;
         j = n_edges % 16;
         if (cpha ? (j % 2 == 1) : (j % 2 == 0))
            slv_rx[(n_edges / 16) % 80][bit_pos(n_edges, cpha, lsbf)] = mosi;
         n_edges++;
      end
   end

   task automatic check(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_burst(string req, bit cp, bit ch, bit lf, bit ds, int nb, int nt, int extra, bit hold);
      int cyc, bad, k;
      @(negedge clk);
      cpol = cp; cpha = ch; lsbf = lf; disc = ds; div = int'($urandom % 3);
      irqen = 1'($urandom % 2);
      txfl = 1'b1; rxfl = 1'b1;
      @(negedge clk);
      txfl = 1'b0; rxfl = 1'b0;
      for (int i = 0; i < nt + extra; i++) begin
         txb[i] = 8'($urandom); txpush = 1'b1; txd = txb[i];
         @(negedge clk);
      end
      txpush = 1'b0;
      for (int i = 0; i < 80; i++) slv_rx[i] = 8'hxx;
      seedv = int'($urandom % 256); n_edges = 0; armed = 1'b1;
      if (hold) en = 1'b0;
      blen = 24'(nb); tlen = 24'(nt); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (hold) begin
         repeat (200) @(negedge clk);
         check("R10", "busy while gated", int'(busy), 1);
         check("R10", "edges while gated", n_edges, 0);
         check("R10", "tc while gated", int'(tc), 0);
         en = 1'b1;
      end
      cyc = 0; bad = 0;
      while (busy && cyc < 40000) begin
         if (tc) bad++;
         @(negedge clk);
         cyc++;
      end
      check(req, "burst finished", int'(busy), 0);
      check("R7", "tc set with busy fall", int'(tc), 1);
      check("R7", "tc early count", bad, 0);
      if (nb == 0) check("R8", "zero burst latency", cyc, 1);
      check("R9", "irq follows enable", int'(irq), int'(irqen));
      check(nb == 0 ? "R8" : "R2", "sck edges", n_edges, 16 * nb);
      for (k = 0; k < nb; k++)
         check(k >= nt ? "R5" : req, "slave rx byte",
               int'(slv_rx[k]), (k < nt) ? int'(txb[k]) : 0);
      check("R5", "tx level after", int'(lvl[22:16]), extra);
      check(ds ? "R6" : "R2", "rx level after", int'(lvl[6:0]), ds ? 0 : nb);
      if (!ds) begin
         for (k = 0; k < nb; k++) begin
            check(req, "master rx byte", int'(rxd), int'(slave_byte(k, seedv)));
            rxpop = 1'b1;
            @(negedge clk);
            rxpop = 1'b0;
         end
      end
      armed = 1'b0;
      tcclr = 1'b1;
      @(negedge clk);
      tcclr = 1'b0;
      check("R9", "tc cleared", int'(tc), 0);
      check("R9", "irq cleared", int'(irq), 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy", int'(busy), 0);
      check("R1", "tc", int'(tc), 0);
      check("R1", "irq", int'(irq), 0);
      check("R1", "levels", int'(lvl), 0);
      check("R1", "sck idle", int'(sck), 1);
      cpol = 1'b0;
      @(negedge clk);
      check("R3", "sck idle follows polarity", int'(sck), 0);

      // directed corners
      run_burst("R2", 0, 0, 0, 0, 3, 3, 2, 0);
      run_burst("R3", 1, 0, 0, 0, 2, 2, 0, 0);
      run_burst("R3", 0, 1, 0, 0, 2, 2, 1, 0);
      run_burst("R3", 1, 1, 0, 0, 3, 3, 0, 0);
      run_burst("R4", 0, 0, 1, 0, 3, 3, 0, 0);
      run_burst("R4", 1, 1, 1, 0, 2, 2, 0, 0);
      run_burst("R5", 0, 0, 0, 0, 5, 2, 3, 0);
      run_burst("R5", 0, 1, 0, 0, 3, 0, 2, 0);
      run_burst("R8", 1, 0, 0, 0, 0, 0, 2, 0);
      run_burst("R6", 0, 0, 0, 1, 4, 4, 0, 0);
      run_burst("R11", 1, 1, 0, 0, 64, 63, 1, 0);
      run_burst("R10", 0, 0, 0, 0, 2, 2, 0, 1);

      // queue capacity and flush
      @(negedge clk);
      for (int i = 0; i < 70; i++) begin
         txpush = 1'b1; txd = 8'(i);
         @(negedge clk);
      end
      txpush = 1'b0;
      check("R11", "tx level full", int'(lvl[22:16]), 64);
      check("R11", "other level bits", int'(lvl & 32'hff80_ff80), 0);
      txfl = 1'b1;
      @(negedge clk);
      txfl = 1'b0;
      check("R11", "tx level flushed", int'(lvl[22:16]), 0);

      // random bursts
      for (int r = 0; r < 24; r++) begin
         int nb, nt, ex, cap;
         nb = int'($urandom % 65);
         cap = (nb < 63) ? nb : 63;
         nt = int'($urandom % (cap + 1));
         ex = (64 - nt < 2) ? 64 - nt : 2;
         run_burst("R3", 1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 4) == 0, nb, nt, ex, 0);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(4 * 190000);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule